// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat access to a synchronous SRAM. A fresh address comes from the external address bus when either of two active-low load strobes is low at a rising clock edge. One strobe belongs to the processor and one to the cache controller. After the load, each clock edge with the active-low advance input low and no strobe moves the access to its next beat. The next address is formed internally by changing only the two least significant bits.

A static order select sets how those low bits step. With the select high, each beat's low bits are the starting low bits XOR a beat count, which is the interleaved order. With the select low, the beat count is added to the starting low bits modulo four, which is the linear wrap-around order. The upper address bits keep the value captured at load. The address, a valid flag and a flag that names which strobe caused the last load are all registered outputs.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `cur_addr` becomes 0, `addr_valid` becomes 0 and `src_proc` becomes 0.
- R2: With `proc_stb_n` low at an edge, `cur_addr` equals the sampled `ext_addr` after that edge, `addr_valid` is 1 and `src_proc` is 1.
- R3: With `ctrl_stb_n` low and `proc_stb_n` high at an edge, `cur_addr` equals the sampled `ext_addr`, `addr_valid` is 1 and `src_proc` is 0.
- R4: With both strobes low at the same edge, the processor strobe wins: the address is loaded and `src_proc` is 1.
- R5: A load takes place whatever the level of `adv_n`. The loaded address is beat 0 of a new burst.
- R6: With `order_sel` = 1 (interleaved), the low two bits on beat k (k = 0..3) equal the starting low bits XOR k.
- R7: With `order_sel` = 0 (linear), the low two bits on beat k equal the starting low bits plus k, modulo 4.
- R8: The fourth advance after a load returns `cur_addr` to the loaded address. Further advances repeat the same four-beat order.
- R9: Bits [ADDR_W-1:2] of `cur_addr` keep their loaded value across advances, and `ext_addr` has no effect while both strobes are high.
- R10: With both strobes high and `adv_n` high, `cur_addr` holds its value.
- R11: Before the first load after reset, `adv_n` low has no effect: `cur_addr` stays 0 and `addr_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_stb_n | input | 1 | Processor load strobe, active low, higher priority |
| ctrl_stb_n | input | 1 | Controller load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 1 = interleaved (XOR) order, 0 = linear (add, wrap) order |
| ext_addr | input | ADDR_W | External start address |
| cur_addr | output | ADDR_W | Registered current burst address |
| addr_valid | output | 1 | At least one load since reset |
| src_proc | output | 1 | Last load came from the processor strobe |

## Verification
The sweep covers every pair of order select and starting low bits. Each pair is loaded three ways: processor strobe alone, controller strobe alone, and both at once. This separates the two orders, because they differ only for odd starting values and from beat 1 on, and it tests the priority flag. Each burst runs six advances, so the wrap after beat 3 is seen both at the loaded address and on the beat after it. The load that uses the controller strobe also has advance held low, which shows the load is independent of advance. The external bus is inverted during the advances and a hold cycle follows each beat, which exposes any leak of the bus into upper bits or any drift with no command.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_PROC = 2'd1,
    LD_CTRL = 2'd2
  } load_src_e;
endpackage

// File: rtl/burst_load_arb.sv
module burst_load_arb
  import burst_seq_pkg::*;
(
  input  logic      proc_stb_n,
  input  logic      ctrl_stb_n,
  output logic      load,
  output load_src_e src
);
  always_comb begin
    if (!proc_stb_n)      src = LD_PROC;
    else if (!ctrl_stb_n) src = LD_CTRL;
    else                  src = LD_NONE;
    load = (src != LD_NONE);
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_nxt
);
  logic [BEAT_W-1:0] beat_q;

  always_comb begin
    if (load)      beat_nxt = '0;
    else if (step) beat_nxt = beat_q + BEAT_W'(1);
    else           beat_nxt = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end
endmodule

// File: rtl/burst_offset_gen.sv
module burst_offset_gen #(
  parameter int BEAT_W = 2
) (
  input  logic              linear_sel,
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] offs
);
  logic [BEAT_W-1:0] xor_offs;
  logic [BEAT_W-1:0] add_offs;

  genvar gi;
  generate
    for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
      assign xor_offs[gi] = start_lo[gi] ^ beat[gi];
    end
  endgenerate

  assign add_offs = start_lo + beat;
  assign offs     = linear_sel ? add_offs : xor_offs;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              addr_valid,
  output logic              src_proc
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              load;
  load_src_e         src;
  logic              step;
  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] offs;
  logic [BEAT_W-1:0] start_lo_q;
  logic [UP_W-1:0]   upper_q;
  logic [BEAT_W-1:0] low_q;
  logic              valid_q;
  logic              src_proc_q;

  burst_load_arb u_arb (
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .load       (load),
    .src        (src)
  );

  assign step = !adv_n && valid_q && !load;

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .beat_nxt (beat_nxt)
  );

  burst_offset_gen #(.BEAT_W(BEAT_W)) u_offs (
    .linear_sel (!order_sel),
    .start_lo   (start_lo_q),
    .beat       (beat_nxt),
    .offs       (offs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q    <= '0;
      low_q      <= '0;
      start_lo_q <= '0;
      valid_q    <= 1'b0;
      src_proc_q <= 1'b0;
    end else if (load) begin
      upper_q    <= ext_addr[ADDR_W-1:BEAT_W];
      low_q      <= ext_addr[BEAT_W-1:0];
      start_lo_q <= ext_addr[BEAT_W-1:0];
      valid_q    <= 1'b1;
      src_proc_q <= (src == LD_PROC);
    end else if (step) begin
      low_q      <= offs;
    end
  end

  assign cur_addr   = {upper_q, low_q};
  assign addr_valid = valid_q;
  assign src_proc   = src_proc_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_stb_n,
  input logic              ctrl_stb_n,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              addr_valid,
  input logic              src_proc
);
  // R2
  load_proc_chk: assert property (@(posedge clk) disable iff (rst)
    !proc_stb_n |=> (cur_addr == $past(ext_addr)) && addr_valid && src_proc);

  // R3
  load_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_stb_n && !ctrl_stb_n) |=> (cur_addr == $past(ext_addr)) && addr_valid && !src_proc);

  // R9
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_stb_n && ctrl_stb_n) |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_stb_n && ctrl_stb_n && adv_n) |=> $stable(cur_addr));

  // R7
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_stb_n && ctrl_stb_n && !adv_n && addr_valid && !order_sel)
      |=> cur_addr[BEAT_W-1:0] == BEAT_W'($past(cur_addr[BEAT_W-1:0]) + 1'b1));

  // R11
  no_load_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_stb_n && ctrl_stb_n && !addr_valid) |=> !addr_valid && (cur_addr == '0));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .proc_stb_n (proc_stb_n),
  .ctrl_stb_n (ctrl_stb_n),
  .adv_n      (adv_n),
  .order_sel  (order_sel),
  .ext_addr   (ext_addr),
  .cur_addr   (cur_addr),
  .addr_valid (addr_valid),
  .src_proc   (src_proc)
);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          proc_stb_n = 1'b1;
  logic          ctrl_stb_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;
  logic          addr_valid;
  logic          src_proc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .adv_n      (adv_n),
    .order_sel  (order_sel),
    .ext_addr   (ext_addr),
    .cur_addr   (cur_addr),
    .addr_valid (addr_valid),
    .src_proc   (src_proc)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    tick();
    tick();
    // R1: reset state
    chk("R1 addr", cur_addr, '0);
    chk("R1 valid", AW'(addr_valid), '0);
    chk("R1 src", AW'(src_proc), '0);
    rst = 1'b0;
    // R11: advance before any load
    adv_n = 1'b0;
    ext_addr = 18'h2_5A5F;
    tick();
    tick();
    chk("R11 addr", cur_addr, '0);
    chk("R11 valid", AW'(addr_valid), '0);
    adv_n = 1'b1;

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int kind = 0; kind < 3; kind++) begin
          logic [15:0]   up;
          logic [AW-1:0] base;
          up   = 16'(m * 4099 + s * 613 + kind * 97 + 16'h05A3);
          base = {up, 2'(s)};
          order_sel  = m[0];
          ext_addr   = base;
          proc_stb_n = (kind == 1);
          ctrl_stb_n = (kind == 0);
          // R5: controller load made with advance held low
          adv_n      = (kind != 1);
          tick();
          if (kind == 0)      chk("R2 load", cur_addr, base);
          else if (kind == 1) chk("R3 load R5", cur_addr, base);
          else                chk("R4 load", cur_addr, base);
          chk("R2 R3 valid", AW'(addr_valid), AW'(1));
          chk("R4 src", AW'(src_proc), AW'(kind != 1));
          proc_stb_n = 1'b1;
          ctrl_stb_n = 1'b1;
          ext_addr   = ~base;
          for (int k = 1; k <= 6; k++) begin
            logic [1:0]    lo;
            logic [AW-1:0] exp;
            adv_n = 1'b0;
            tick();
            lo  = (m == 1) ? 2'(s ^ (k % 4)) : 2'((s + k) % 4);
            exp = {up, lo};
            if (m == 1) chk("R6 R9 interleaved beat", cur_addr, exp);
            else        chk("R7 R9 linear beat", cur_addr, exp);
            if (k == 4) chk("R8 wrap", cur_addr, base);
            adv_n = 1'b1;
            tick();
            chk("R10 hold", cur_addr, exp);
          end
        end
      end
    end
    // R1: reset after activity
    rst = 1'b1;
    tick();
    chk("R1 re-reset addr", cur_addr, '0);
    chk("R1 re-reset valid", AW'(addr_valid), '0);
    rst = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule